// File: doc/BRIEF.md
# Word-Mapped Serial Port with Receive Queue

This block is an 8N1 asynchronous serial port that a host reaches through a small synchronous register bus. Eight byte-wide registers each take one word slot, so the bus carries a word index. Four of the slots hold fixed identification bytes. One slot is the data port: a write launches a byte and a read takes the oldest received byte. One slot combines status flags with the two interrupt enables. The last two slots hold the low and high halves of a 16-bit divisor.

A tick generator divides the clock by (divisor + 1) and so produces four ticks per bit. The transmit machine has the states TX_IDLE, TX_START, TX_DATA and TX_STOP. A write to the data port while in TX_IDLE moves it to TX_START. After four ticks it moves to TX_DATA. After the eighth data bit it moves to TX_STOP, and after four more ticks it returns to TX_IDLE.

The receive machine has the states RX_IDLE, RX_START, RX_DATA and RX_STOP. A tick that sees the line low moves RX_IDLE to RX_START. Two ticks later the line is checked again: if it is still low the machine goes to RX_DATA, otherwise it returns to RX_IDLE. After the eighth centre sample it goes to RX_STOP. The stop sample then returns it to RX_IDLE and stores the byte only if the line is high. Stored bytes go into a four-entry queue. A sticky overrun flag records a byte that found the queue full. One interrupt line combines the receive and transmit-room conditions, and each has its own enable.

Top module: `serial_port_mm`

## Requirements
- R1: After reset, word 5 (status) reads 0x81, words 6 and 7 (divisor) read 0, the irq output is 0, and words 0 to 3 read the constant bytes 0xC3, 0x51, 0x02, 0x10.
- R2: Words 0 to 3 are read-only, and a write to them leaves the value read back unchanged.
- R3: Word 6 holds divisor bits 7:0 and word 7 holds bits 15:8, and both read back as written. One bit lasts 4 × (divisor + 1) clock cycles.
- R4: A write to word 4 while status bit 7 (transmitter idle) is 1 sends a frame with one low start bit, eight data bits LSB first and one high stop bit. Bit 7 reads 0 until the frame ends. A write to word 4 while bit 7 is 0 is ignored.
- R5: The receiver takes a byte LSB first. A start pulse that is gone by mid-bit yields no byte, and a frame whose stop bit is 0 is discarded.
- R6: Received bytes are read back from word 4 in arrival order, up to four of them. Status bit 0 (queue empty) is 1 only when none remain. Reading word 4 while the queue is empty returns 0 and changes nothing.
- R7: A byte that arrives while four are queued is dropped, the queue contents are kept, and status bit 3 (overrun) is set.
- R8: Status bit 3 stays set until word 5 is written with bit 3 = 1. Writing bit 3 = 0 leaves it set.
- R9: Writes to word 5 set bit 1 (transmit interrupt enable) and bit 2 (receive interrupt enable). irq = (bit2 AND (queue not empty OR overrun)) OR (bit1 AND transmitter idle).
- R10: When a read of word 4 and the storing of a new byte fall in the same cycle, both take effect: the old byte is returned and the new one is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the queue when word 4 is addressed) |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ser_rx | input | 1 | Serial input, idle high |
| ser_tx | output | 1 | Serial output, idle high |
| irq | output | 1 | Combined interrupt |

## Verification
A bus read of the data port and the storing of a newly received byte can land in the same clock cycle. The bench provokes this by preloading one byte and then sending a second frame. Across 32 trials it moves a single data-port read one cycle at a time through the window around the stop-bit sample. In every trial the read must return the preloaded byte, the new byte must be the next one read, and a further read must find the queue empty with no overrun flagged.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int SP_BYTE_W = 8;
    localparam int SP_DIV_W  = 2 * SP_BYTE_W;
    localparam int SP_OVS    = 4;
    localparam int SP_PH_W   = $clog2(SP_OVS);

    localparam logic [2:0] A_ID0  = 3'd0;
    localparam logic [2:0] A_ID1  = 3'd1;
    localparam logic [2:0] A_ID2  = 3'd2;
    localparam logic [2:0] A_ID3  = 3'd3;
    localparam logic [2:0] A_DATA = 3'd4;
    localparam logic [2:0] A_STAT = 3'd5;
    localparam logic [2:0] A_DIVL = 3'd6;
    localparam logic [2:0] A_DIVH = 3'd7;

    localparam int ST_RXEMPTY = 0;
    localparam int ST_TXIEN   = 1;
    localparam int ST_RXIEN   = 2;
    localparam int ST_OERR    = 3;
    localparam int ST_TXEMPTY = 7;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/sp_tick.sv
module sp_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Ticks are spaced by div+1 cycles while the divisor holds still.
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [SP_BYTE_W-1:0] din,
    output logic                 txd,
    output logic                 idle
);
    localparam logic [SP_PH_W-1:0] PH_LAST  = SP_PH_W'(SP_OVS - 1);
    localparam int                 BN_W     = $clog2(SP_BYTE_W);
    localparam logic [BN_W-1:0]    BN_LAST  = BN_W'(SP_BYTE_W - 1);

    tx_state_e            st, st_nx;
    logic [SP_PH_W-1:0]   ph, ph_nx;
    logic [BN_W-1:0]      bn, bn_nx;
    logic [SP_BYTE_W-1:0] sh, sh_nx;

    always_comb begin
        st_nx = st;
        ph_nx = ph;
        bn_nx = bn;
        sh_nx = sh;
        unique case (st)
            TX_IDLE: if (load) begin
                st_nx = TX_START;
                ph_nx = '0;
                sh_nx = din;
            end
            TX_START: if (tick) begin
                if (ph == PH_LAST) begin
                    st_nx = TX_DATA;
                    ph_nx = '0;
                    bn_nx = '0;
                end else ph_nx = ph + 1'b1;
            end
            TX_DATA: if (tick) begin
                if (ph == PH_LAST) begin
                    ph_nx = '0;
                    sh_nx = {1'b0, sh[SP_BYTE_W-1:1]};
                    bn_nx = bn + 1'b1;
                    if (bn == BN_LAST) st_nx = TX_STOP;
                end else ph_nx = ph + 1'b1;
            end
            TX_STOP: if (tick) begin
                if (ph == PH_LAST) st_nx = TX_IDLE;
                else               ph_nx = ph + 1'b1;
            end
            default: st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= TX_IDLE;
            ph <= '0;
            bn <= '0;
            sh <= '0;
        end else begin
            st <= st_nx;
            ph <= ph_nx;
            bn <= bn_nx;
            sh <= sh_nx;
        end
    end

    always_comb begin
        idle = (st == TX_IDLE);
        unique case (st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            default:  txd = 1'b1;
        endcase
    end

    // An accepted launch drives the start bit on the very next cycle.
    p_launch_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && idle) |=> (!txd && !idle));
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rxd,
    output logic                 push,
    output logic [SP_BYTE_W-1:0] data
);
    localparam logic [SP_PH_W-1:0] PH_LAST = SP_PH_W'(SP_OVS - 1);
    localparam logic [SP_PH_W-1:0] PH_MID  = SP_PH_W'(SP_OVS / 2 - 1);
    localparam int                 BN_W    = $clog2(SP_BYTE_W);
    localparam logic [BN_W-1:0]    BN_LAST = BN_W'(SP_BYTE_W - 1);

    rx_state_e            st, st_nx;
    logic [SP_PH_W-1:0]   ph, ph_nx;
    logic [BN_W-1:0]      bn, bn_nx;
    logic [SP_BYTE_W-1:0] sh, sh_nx;
    logic                 push_nx;

    always_comb begin
        st_nx   = st;
        ph_nx   = ph;
        bn_nx   = bn;
        sh_nx   = sh;
        push_nx = 1'b0;
        unique case (st)
            RX_IDLE: if (tick && !rxd) begin
                st_nx = RX_START;
                ph_nx = '0;
            end
            RX_START: if (tick) begin
                if (ph == PH_MID) begin
                    if (!rxd) begin
                        st_nx = RX_DATA;
                        ph_nx = '0;
                        bn_nx = '0;
                    end else st_nx = RX_IDLE;
                end else ph_nx = ph + 1'b1;
            end
            RX_DATA: if (tick) begin
                if (ph == PH_LAST) begin
                    ph_nx = '0;
                    sh_nx = {rxd, sh[SP_BYTE_W-1:1]};
                    bn_nx = bn + 1'b1;
                    if (bn == BN_LAST) st_nx = RX_STOP;
                end else ph_nx = ph + 1'b1;
            end
            RX_STOP: if (tick) begin
                if (ph == PH_LAST) begin
                    st_nx   = RX_IDLE;
                    push_nx = rxd;
                end else ph_nx = ph + 1'b1;
            end
            default: st_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            ph   <= '0;
            bn   <= '0;
            sh   <= '0;
            push <= 1'b0;
        end else begin
            st   <= st_nx;
            ph   <= ph_nx;
            bn   <= bn_nx;
            sh   <= sh_nx;
            push <= push_nx;
        end
    end

    always_comb data = sh;

    // A stored byte is always followed by a return to the idle hunt state.
    p_push_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st == RX_IDLE));
endmodule

// File: rtl/sp_fifo.sv
module sp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] C_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == C_FULL);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || pop);
    assign ovf     = push && full && !pop;
    assign dout    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == P_LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == P_LAST) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= C_FULL);

    // A dropped arrival leaves the queue as it was.
    p_drop_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (full && $stable(rp) && $stable(wp)));

    // A pop that meets a push on a full queue keeps it full.
    p_pop_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full) |=> full);
endmodule

// File: rtl/serial_port_mm.sv
module serial_port_mm
    import sp_pkg::*;
#(
    parameter int         FIFO_DEPTH = 4,
    parameter logic [7:0] ID_B0      = 8'hC3,
    parameter logic [7:0] ID_B1      = 8'h51,
    parameter logic [7:0] ID_B2      = 8'h02,
    parameter logic [7:0] ID_B3      = 8'h10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ser_rx,
    output logic       ser_tx,
    output logic       irq
);
    logic [SP_DIV_W-1:0]  div;
    logic                 txien, rxien, oerr;
    logic [1:0]           rx_sync;
    logic                 tick, tx_idle;
    logic                 rx_push;
    logic [SP_BYTE_W-1:0] rx_byte, q_dout;
    logic                 q_empty, q_full, q_ovf, q_pop;
    logic                 wr_stat;
    logic [7:0]           status;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], ser_rx};
    end

    sp_tick #(.DIV_W(SP_DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
    );

    sp_tx tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(bus_wr && bus_addr == A_DATA), .din(bus_wdata),
        .txd(ser_tx), .idle(tx_idle)
    );

    sp_rx rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rx_sync[1]),
        .push(rx_push), .data(rx_byte)
    );

    assign q_pop = bus_rd && bus_addr == A_DATA;

    sp_fifo #(.DEPTH(FIFO_DEPTH), .W(SP_BYTE_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(q_pop), .dout(q_dout), .empty(q_empty), .full(q_full),
        .ovf(q_ovf)
    );

    assign wr_stat = bus_wr && bus_addr == A_STAT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div   <= '0;
            txien <= 1'b0;
            rxien <= 1'b0;
            oerr  <= 1'b0;
        end else begin
            if (bus_wr) begin
                unique case (bus_addr)
                    A_STAT: begin
                        txien <= bus_wdata[ST_TXIEN];
                        rxien <= bus_wdata[ST_RXIEN];
                    end
                    A_DIVL:  div[7:0]  <= bus_wdata;
                    A_DIVH:  div[15:8] <= bus_wdata;
                    default: ;
                endcase
            end
            if (q_ovf)                             oerr <= 1'b1;
            else if (wr_stat && bus_wdata[ST_OERR]) oerr <= 1'b0;
        end
    end

    always_comb begin
        status             = '0;
        status[ST_RXEMPTY] = q_empty;
        status[ST_TXIEN]   = txien;
        status[ST_RXIEN]   = rxien;
        status[ST_OERR]    = oerr;
        status[ST_TXEMPTY] = tx_idle;
    end

    always_comb begin
        unique case (bus_addr)
            A_ID0:   bus_rdata = ID_B0;
            A_ID1:   bus_rdata = ID_B1;
            A_ID2:   bus_rdata = ID_B2;
            A_ID3:   bus_rdata = ID_B3;
            A_DATA:  bus_rdata = q_empty ? '0 : q_dout;
            A_STAT:  bus_rdata = status;
            A_DIVL:  bus_rdata = div[7:0];
            default: bus_rdata = div[15:8];
        endcase
    end

    always_comb irq = (rxien && (!q_empty || oerr)) || (txien && tx_idle);

    p_oerr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oerr) |-> $past(q_full));

    p_oerr_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[ST_OERR] && !q_ovf) |=> !oerr);

    p_oerr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (oerr && !(wr_stat && bus_wdata[ST_OERR])) |=> oerr);

    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!txien && !rxien) |-> !irq);
endmodule

// File: tb/serial_port_mm_tb.sv
module serial_port_mm_tb_top;
    localparam int BITC = 16;   // clocks per bit with divisor 3

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ser_rx = 1'b1;
    logic       ser_tx, irq;

    int n_chk = 0, n_fail = 0;
    bit [7:0] mq[$];
    bit m_oerr = 0, m_txien = 0, m_rxien = 0;
    bit mon_en = 0;

    always #5 clk = ~clk;

    serial_port_mm dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_rx(ser_rx), .ser_tx(ser_tx), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Reference irq compared every clock while the model is in step.
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            bit e;
            e = (m_rxien && (mq.size() > 0 || m_oerr)) || m_txien;
            chk(irq == e, "R9 irq per-clock", int'(irq), int'(e));
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (a == 3'd5) begin
            m_txien = d[1];
            m_rxien = d[2];
            if (d[3]) m_oerr = 0;
        end
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        if (a == 3'd4 && mq.size() > 0) void'(mq.pop_front());
        #1 bus_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
        logic [7:0] d;
        bus_read(a, d);
        chk(d == e, req, d, e);
    endtask

    task automatic expect_pop(input string req);
        logic [7:0] d, e;
        e = (mq.size() > 0) ? mq[0] : 8'h00;
        bus_read(3'd4, d);
        chk(d == e, req, d, e);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit stop_ok);
        logic [9:0] fr;
        fr = {stop_ok, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) ser_rx = fr[i];
            repeat (BITC - 1) @(negedge clk);
        end
        @(negedge clk) ser_rx = 1'b1;
        if (stop_ok) begin
            if (mq.size() < 4) mq.push_back(b);
            else               m_oerr = 1;
        end
    endtask

    task automatic cap_tx(input int p, output logic [7:0] b, output bit stop, output bit seen);
        int t;
        seen = 0; b = '0; stop = 0; t = 0;
        while (t < 4000 && ser_tx) begin
            @(negedge clk);
            t++;
        end
        if (!ser_tx) begin
            seen = 1;
            repeat (p + p / 2) @(negedge clk);
            for (int k = 0; k < 8; k++) begin
                b[k] = ser_tx;
                repeat (p) @(negedge clk);
            end
            stop = ser_tx;
        end
    endtask

    task automatic tx_frame_test(input int p, input logic [7:0] v, input string req);
        logic [7:0] got, st;
        bit stop, seen;
        fork
            cap_tx(p, got, stop, seen);
            begin
                bus_write(3'd4, v);
                bus_read(3'd5, st);
                chk(st[7] == 1'b0, {req, " busy flag"}, st, 8'h00);
                bus_write(3'd4, ~v);   // ignored while busy
            end
        join
        chk(seen, {req, " start seen"}, seen, 1);
        chk(got == v, {req, " data"}, got, v);
        chk(stop == 1'b1, {req, " stop"}, stop, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk(irq == 1'b0, "R1 irq", irq, 0);
        expect_reg(3'd0, 8'hC3, "R1 id0");
        expect_reg(3'd1, 8'h51, "R1 id1");
        expect_reg(3'd2, 8'h02, "R1 id2");
        expect_reg(3'd3, 8'h10, "R1 id3");
        expect_reg(3'd5, 8'h81, "R1 status");
        expect_reg(3'd6, 8'h00, "R1 divl");
        expect_reg(3'd7, 8'h00, "R1 divh");

        // R2 read-only identification
        bus_write(3'd0, 8'hFF);
        bus_write(3'd3, 8'h00);
        expect_reg(3'd0, 8'hC3, "R2 id0 after write");
        expect_reg(3'd3, 8'h10, "R2 id3 after write");

        // R3 divisor readback and 8-clock bit (divisor 1)
        bus_write(3'd7, 8'h12);
        expect_reg(3'd7, 8'h12, "R3 divh");
        bus_write(3'd7, 8'h00);
        bus_write(3'd6, 8'h01);
        expect_reg(3'd6, 8'h01, "R3 divl");
        tx_frame_test(8, 8'h96, "R3 R4 tx div1");
        repeat (40) @(negedge clk);

        // R4 transmit at divisor 3, busy write ignored
        bus_write(3'd6, 8'h03);
        tx_frame_test(BITC, 8'hA5, "R4 tx div3");
        repeat (40) @(negedge clk);
        begin
            bit quiet = 1;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (!ser_tx) quiet = 0;
            end
            chk(quiet, "R4 no second frame", quiet, 1);
        end
        expect_reg(3'd5, 8'h81, "R4 idle status");

        mon_en = 1;
        // R9 transmit-room interrupt
        bus_write(3'd5, 8'h02);
        @(negedge clk);
        chk(irq == 1'b1, "R9 tx irq", irq, 1);
        bus_write(3'd5, 8'h04);
        @(negedge clk);
        chk(irq == 1'b0, "R9 rx enable no data", irq, 0);

        // R5 receive, R6 order
        mon_en = 0;
        send_rx(8'h3C, 1'b1);
        send_rx(8'hC1, 1'b1);
        mon_en = 1;
        @(negedge clk);
        chk(irq == 1'b1, "R9 rx irq", irq, 1);
        expect_reg(3'd5, 8'h84, "R6 status not empty");
        expect_pop("R5 R6 first byte");
        expect_pop("R6 second byte");
        expect_reg(3'd5, 8'h85, "R6 empty again");
        expect_pop("R6 empty read returns 0");
        expect_reg(3'd5, 8'h85, "R6 empty read no effect");

        // R5 glitch start and bad stop
        mon_en = 0;
        @(negedge clk) ser_rx = 1'b0;
        repeat (4) @(negedge clk);
        ser_rx = 1'b1;
        repeat (200) @(negedge clk);
        send_rx(8'h77, 1'b0);
        repeat (20) @(negedge clk);
        mon_en = 1;
        expect_reg(3'd5, 8'h85, "R5 glitch and bad stop discarded");

        // R7 overrun with R8 clear
        mon_en = 0;
        for (int i = 0; i < 5; i++) send_rx(8'h10 + 8'(i), 1'b1);
        mon_en = 1;
        @(negedge clk);
        expect_reg(3'd5, 8'h8C, "R7 overrun flagged");
        bus_write(3'd5, 8'h04);
        expect_reg(3'd5, 8'h8C, "R8 write 0 keeps flag");
        bus_write(3'd5, 8'h0C);
        expect_reg(3'd5, 8'h84, "R8 write 1 clears flag");
        for (int i = 0; i < 4; i++) expect_pop("R7 kept contents");
        expect_reg(3'd5, 8'h85, "R7 fifth byte dropped");

        // R10 read and store in the same cycle, swept
        mon_en = 0;
        for (int off = 0; off < 32; off++) begin
            logic [7:0] a_v, b_v, r;
            a_v = 8'h40 + 8'(off);
            b_v = 8'hB0 ^ 8'(off);
            send_rx(a_v, 1'b1);
            fork
                send_rx(b_v, 1'b1);
                begin
                    repeat (9 * BITC + off) @(negedge clk);
                    bus_read(3'd4, r);
                    chk(r == a_v, "R10 old byte returned", r, a_v);
                end
            join
            expect_pop("R10 new byte kept");
            expect_reg(3'd5, 8'h85, "R10 empty no overrun");
        end

        finish_run();
    end
endmodule